// File: doc/BRIEF.md
# SIMD Lane Interleave and Insert Unit

This block rearranges the lanes of two 64-bit operands, A and B. It treats them as a single 128-bit value. A fills the low half, so A supplies lanes 0..N-1, and B supplies lanes N..2N-1. Lane 0 is always the least significant lane.

A 4-bit opcode picks the operation:
- an unpack interleave of bytes, halfwords or words, taken from the low halves or the high halves of the two operands;
- a halfword insert, which drops the lowest halfword of B into one of the four halfword slots of A.

An execution pipeline issues one operation per cycle by raising `in_valid`. The permuted result appears in a register one cycle later, together with `out_valid`.

Top module: `simd_lane_mixer`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` in any cycle equals `in_valid` of the previous cycle. The result of an operation is visible in the cycle after it is accepted.
- R3: In a cycle with `in_valid` low, `result` keeps its previous value, whatever the other inputs do.
- R4: Opcode 4'b0000 (byte interleave, low) produces result bytes 0..7 = concatenation bytes 0,8,1,9,2,10,3,11. Byte k of the concatenation is bits [8k+7:8k] of {B,A}.
- R5: Opcode 4'b0001 (byte interleave, high) produces result bytes 0..7 = concatenation bytes 4,12,5,13,6,14,7,15.
- R6: Opcodes 4'b0100 and 4'b0101 (halfword interleave, low and high) produce result halfwords 0..3 = concatenation halfwords 0,4,1,5 and 2,6,3,7 respectively.
- R7: Opcodes 4'b1000 and 4'b1001 (word interleave, low and high) produce result words 0..1 = concatenation words 0,2 and 1,3 respectively.
- R8: Opcode 4'b11kk writes B[15:0] into halfword slot k of the result, at bits [16k+15:16k]. The other three halfwords are taken unchanged from A.
- R9: For the interleave opcodes (bits [3:2] not equal to 2'b11), opcode bit 1 is ignored. Opcode 4'bgg1h gives the same result as 4'bgg0h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 4 | [3:2] granularity (00 byte, 01 halfword, 10 word, 11 insert); [0] high half for interleave; [1:0] slot for insert |
| src_a | input | 64 | First operand, lanes 0..N-1 of the concatenation |
| src_b | input | 64 | Second operand, lanes N..2N-1 of the concatenation |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered permutation result |

## Verification
The only state is the result register and the valid flag. A wrong value in either shows at the ports in the very next cycle.

A wrong lane select shows up as a misplaced byte. The bench therefore uses operands in which every byte is distinct, so any swapped or duplicated lane changes the output word. A register that reloads while `in_valid` is low shows up as a changed `result` in the idle cycle after an operation. A stuck or delayed strobe shows up as an `out_valid` mismatch one cycle after the input valid.

// File: rtl/simd_lane_mixer.sv
module simd_lane_mixer #(
  parameter int DATA_W = 64,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  localparam int NGRAN = 3;
  localparam int HW    = 16;
  localparam int SLOTS = DATA_W / HW;

  wire logic [NGRAN-1:0][DATA_W-1:0] ilv_lo;
  wire logic [NGRAN-1:0][DATA_W-1:0] ilv_hi;
  wire logic [SLOTS-1:0][DATA_W-1:0] ins;

  for (genvar g = 0; g < NGRAN; g++) begin : g_gran
    localparam int LW   = 8 << g;
    localparam int HALF = DATA_W / LW / 2;
    for (genvar i = 0; i < HALF; i++) begin : g_lane
      assign ilv_lo[g][(2*i)*LW   +: LW] = src_a[i*LW +: LW];
      assign ilv_lo[g][(2*i+1)*LW +: LW] = src_b[i*LW +: LW];
      assign ilv_hi[g][(2*i)*LW   +: LW] = src_a[(i+HALF)*LW +: LW];
      assign ilv_hi[g][(2*i+1)*LW +: LW] = src_b[(i+HALF)*LW +: LW];
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    for (genvar h = 0; h < SLOTS; h++) begin : g_half
      if (h == k) begin : g_new
        assign ins[k][h*HW +: HW] = src_b[HW-1:0];
      end else begin : g_keep
        assign ins[k][h*HW +: HW] = src_a[h*HW +: HW];
      end
    end
  end

  logic [DATA_W-1:0] perm;

  always_comb begin
    unique case (opcode[3:2])
      2'b00:   perm = opcode[0] ? ilv_hi[0] : ilv_lo[0];
      2'b01:   perm = opcode[0] ? ilv_hi[1] : ilv_lo[1];
      2'b10:   perm = opcode[0] ? ilv_hi[2] : ilv_lo[2];
      default: perm = ins[opcode[1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= perm;
    end
  end

endmodule

// File: rtl/simd_lane_mixer_sva.sv
module simd_lane_mixer_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  opcode,
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic        out_valid,
  input logic [63:0] result
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && result == 64'd0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid == $past(in_valid));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(in_valid) |-> $stable(result));

  a_r4_byte_lo_base: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(in_valid) && $past(opcode) == 4'b0000) |->
      result[15:0] == {$past(src_b[7:0]), $past(src_a[7:0])});

  a_r7_word_hi: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(in_valid) && $past(opcode) == 4'b1001) |->
      result == {$past(src_b[63:32]), $past(src_a[63:32])});

  a_r8_insert_slot: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(in_valid) && $past(opcode[3:2]) == 2'b11) |->
      result[$past(opcode[1:0])*16 +: 16] == $past(src_b[15:0]));

endmodule

bind simd_lane_mixer simd_lane_mixer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
);

// File: tb/simd_lane_mixer_bench.sv
module simd_lane_mixer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_lane_mixer u_simd_lane_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  localparam logic [63:0] A0 = 64'h0706050403020100;
  localparam logic [63:0] B0 = 64'h8F8E8D8C8B8A8988;
  localparam logic [63:0] A1 = 64'hDEADBEEF01234567;
  localparam logic [63:0] B1 = 64'h76543210CAFEF00D;

  function automatic logic [63:0] pick(input logic [63:0] a, input logic [63:0] b,
                                       input int lw, input int sel[8], input int n);
    logic [127:0] cat;
    logic [63:0]  r;
    cat = {b, a};
    r = '0;
    for (int j = 0; j < n; j++)
      for (int t = 0; t < lw; t++)
        r[j*lw + t] = cat[sel[j]*lw + t];
    return r;
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
                                       input logic [63:0] b);
    int bl[8] = '{0,8,1,9,2,10,3,11};
    int bh[8] = '{4,12,5,13,6,14,7,15};
    int hl[8] = '{0,4,1,5,0,0,0,0};
    int hh[8] = '{2,6,3,7,0,0,0,0};
    int wl[8] = '{0,2,0,0,0,0,0,0};
    int wh[8] = '{1,3,0,0,0,0,0,0};
    logic [63:0] r;
    case (op[3:2])
      2'b00: return op[0] ? pick(a, b, 8, bh, 8) : pick(a, b, 8, bl, 8);
      2'b01: return op[0] ? pick(a, b, 16, hh, 4) : pick(a, b, 16, hl, 4);
      2'b10: return op[0] ? pick(a, b, 32, wh, 2) : pick(a, b, 32, wl, 2);
      default: begin
        r = a;
        r[op[1:0]*16 +: 16] = b[15:0];
        return r;
      end
    endcase
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] op,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check64({req, " R2 valid"}, {63'd0, out_valid}, 64'd1);
    check64(req, result, model(op, a, b));
  endtask

  task automatic test_reset;
    check64("R1 valid", {63'd0, out_valid}, 64'd0);
    check64("R1 result", result, 64'd0);
  endtask

  task automatic test_hold;
    logic [63:0] held;
    run_op("R5", 4'b0001, A0, B0);
    held = result;
    opcode = 4'b1100; src_a = A1; src_b = B1;
    @(negedge clk);
    check64("R3 hold", result, held);
    check64("R2 idle valid", {63'd0, out_valid}, 64'd0);
    opcode = 4'b0101;
    @(negedge clk);
    check64("R3 hold2", result, held);
  endtask

  task automatic test_interleave;
    run_op("R4", 4'b0000, A0, B0);
    check64("R4 literal", result, 64'h8B038A0289018800);
    run_op("R5", 4'b0001, A1, B1);
    run_op("R6 low", 4'b0100, A0, B0);
    check64("R6 literal", result, 64'h8B8A03028988_0100);
    run_op("R6 high", 4'b0101, A1, B1);
    run_op("R7 low", 4'b1000, A0, B0);
    run_op("R7 high", 4'b1001, A1, B1);
  endtask

  task automatic test_insert;
    for (int k = 0; k < 4; k++) begin
      run_op("R8", {2'b11, k[1:0]}, A1, B1);
    end
    run_op("R8 slot3", 4'b1111, A0, B0);
    check64("R8 literal", result, 64'h8988050403020100);
  endtask

  task automatic test_bit1_ignored;
    run_op("R9 byte", 4'b0010, A0, B0);
    check64("R9 byte eq", result, model(4'b0000, A0, B0));
    run_op("R9 half", 4'b0111, A1, B1);
    check64("R9 half eq", result, model(4'b0101, A1, B1));
    run_op("R9 word", 4'b1010, A1, B1);
    check64("R9 word eq", result, model(4'b1000, A1, B1));
  endtask

  initial begin
    #10;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_interleave();
    test_hold();
    test_insert();
    test_bit1_ignored();
    run_op("R2 back2back", 4'b0000, A1, B1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule